// File: doc/BRIEF.md
# Two-Context Routed Interrupt Steering Controller

The block collects 32 level-sensitive interrupt request lines and steers each of them onto one of up to 15 output lines, separately for each of two CPU contexts. Every context owns its own enable mask and its own routing table. The same input can therefore reach a different output line, or no line at all, depending on the context. Each context drives its own output vector. An output line stays high for as long as any enabled input that is routed to it is high.

Software programs the block through a small register port. The port has a write strobe, a read strobe, a context select and a byte address whose two low bits are ignored. The address picks the word: enable mask at 0x00, input status at 0x04, and four routing words at 0x08 to 0x14. Each input has a 4-bit routing code. The codes are packed in reverse order, so the highest inputs sit in the first routing word. Input levels pass through a synchronizer before they are used. The output vector is registered.

Top module: `irq_steer`

## Requirements
- R1: While reset is asserted and right after it, every enable bit and routing code of every context is zero, all outputs are low and the read data is zero.
- R2: A read strobe returns the addressed word of the selected context on reg_rdata at the next clock edge, and reg_rdata holds that value until the next read. Word 0x00 is the enable mask. Word 0x04 is the status: the input levels after SYNC clock stages, the same for both contexts. Words 0x08, 0x0C, 0x10 and 0x14 are routing words 0 to 3. All of these read back what was last written.
- R3: The routing code of input i is held in routing word 3 − floor(i/8), at bits 4·(i mod 8)+3 down to 4·(i mod 8). So input 31 uses bits 31:28 of word 0 (0x08), and input 0 uses bits 3:0 of word 3 (0x14).
- R4: A routing code of 0 leaves the input unconnected. A code c from 1 to 15 steers the input to line c−1 of that context, which is irq_out bit ctx·N_OUT + c−1.
- R5: An input whose enable bit in a context is 0 drives no output of that context, whatever its routing code.
- R6: A write to one context changes neither the mask nor the routing of any other context.
- R7: Each output line is the OR of all inputs that are enabled, high and routed to it. A change on an input shows at the output SYNC+1 clock edges later. A configuration write takes effect at the output one edge after the edge that stores it.
- R8: Writes to the status word or to an unmapped word have no effect. Reads of an unmapped word return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 32 | Level-sensitive interrupt requests |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_ctx | input | CTX_W (1) | Context select |
| reg_addr | input | ADDR_W (5) | Byte address, low two bits ignored |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_out | output | N_CTX·N_OUT (30) | Output lines, context c at bits c·N_OUT upward |

## Verification
The bench builds the block with its default values: two contexts, 15 lines each and a two-stage synchronizer. These values make every routing code from 0 to 15 meaningful, including the top code that reaches line 14. Two contexts are enough to steer the same input to different lines and to check that a write to one bank leaves the other unchanged. With the two-stage synchronizer, the three-edge input-to-output delay can be checked edge by edge.

// File: rtl/irq_steer.sv
module irq_steer #(
  parameter int N_OUT  = 15,
  parameter int N_CTX  = 2,
  parameter int SYNC   = 2,
  parameter int ADDR_W = 5,
  parameter int DW     = 32,
  localparam int CTX_W = (N_CTX > 1) ? $clog2(N_CTX) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [DW-1:0]          irq_in,
  input  logic                   reg_wr,
  input  logic                   reg_rd,
  input  logic [CTX_W-1:0]       reg_ctx,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic [DW-1:0]          reg_wdata,
  output logic [DW-1:0]          reg_rdata,
  output logic [N_CTX*N_OUT-1:0] irq_out
);
  localparam int N_IN     = DW;
  localparam int CODE_W   = 4;
  localparam int PER_WORD = DW / CODE_W;
  localparam int NW       = N_IN / PER_WORD;
  localparam int WA_W     = ADDR_W - 2;
  localparam int RW       = (NW > 1) ? $clog2(NW) : 1;

  logic [SYNC-1:0][N_IN-1:0]         sync_q;
  logic [N_IN-1:0]                   status;
  logic [N_CTX-1:0][N_IN-1:0]        mask_q;
  logic [N_CTX-1:0][NW-1:0][DW-1:0]  rt_q;
  logic [N_CTX*N_OUT-1:0]            out_d, out_q;
  logic [DW-1:0]                     rd_val;
  logic [CODE_W-1:0]                 code;

  wire [WA_W-1:0] word   = reg_addr[ADDR_W-1:2];
  wire [WA_W-1:0] rt_off = word - WA_W'(2);
  wire [RW-1:0]   rt_idx = rt_off[RW-1:0];
  wire            hit_mask = (word == '0);
  wire            hit_stat = (word == WA_W'(1));
  wire            hit_rt   = (word >= WA_W'(2)) && (rt_off < WA_W'(NW));

  assign status    = sync_q[SYNC-1];
  assign irq_out   = out_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else begin
      sync_q[0] <= irq_in;
      for (int s = 1; s < SYNC; s++) sync_q[s] <= sync_q[s-1];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mask_q <= '0;
      rt_q   <= '0;
    end else if (reg_wr) begin
      for (int c = 0; c < N_CTX; c++)
        if (reg_ctx == CTX_W'(c)) begin
          if (hit_mask)    mask_q[c]       <= reg_wdata;
          else if (hit_rt) rt_q[c][rt_idx] <= reg_wdata;
        end
    end

  always_comb begin
    rd_val = '0;
    for (int c = 0; c < N_CTX; c++)
      if (reg_ctx == CTX_W'(c)) begin
        if (hit_mask)      rd_val = mask_q[c];
        else if (hit_stat) rd_val = status;
        else if (hit_rt)   rd_val = rt_q[c][rt_idx];
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_val;

  always_comb begin
    out_d = '0;
    code  = '0;
    for (int c = 0; c < N_CTX; c++)
      for (int i = 0; i < N_IN; i++) begin
        code = rt_q[c][NW-1-i/PER_WORD][(i%PER_WORD)*CODE_W +: CODE_W];
        if (mask_q[c][i] && status[i] && code != '0 && int'(code) <= N_OUT)
          out_d[c*N_OUT + int'(code) - 1] = 1'b1;
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
endmodule

// File: rtl/irq_steer_chk.sv
module irq_steer_chk #(
  parameter int N_OUT  = 15,
  parameter int N_CTX  = 2,
  parameter int ADDR_W = 5,
  parameter int DW     = 32,
  parameter int NW     = 4,
  parameter int CTX_W  = 1
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          reg_wr,
  input logic                          reg_rd,
  input logic [CTX_W-1:0]              reg_ctx,
  input logic [ADDR_W-1:0]             reg_addr,
  input logic [DW-1:0]                 reg_rdata,
  input logic [DW-1:0]                 status,
  input logic [N_CTX-1:0][DW-1:0]      mask_q,
  input logic [N_CTX-1:0][NW-1:0][DW-1:0] rt_q,
  input logic [N_CTX*N_OUT-1:0]        irq_out
);
  wire [ADDR_W-3:0] w = reg_addr[ADDR_W-1:2];
  wire mapped = (w == '0) || (w >= 2 && w < 2 + NW);

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (irq_out == '0 && reg_rdata == '0));

  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));

  a_r7_quiet_inputs: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |=> (irq_out == '0));

  a_r8_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !mapped) |=> ($stable(mask_q) && $stable(rt_q)));

  for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
    a_r5_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q[c] == '0) |=> (irq_out[c*N_OUT +: N_OUT] == '0));
    a_r6_ctx_isolated: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_ctx != CTX_W'(c)) |=> ($stable(mask_q[c]) && $stable(rt_q[c])));
  end
endmodule

bind irq_steer irq_steer_chk #(
  .N_OUT(N_OUT), .N_CTX(N_CTX), .ADDR_W(ADDR_W), .DW(DW), .NW(NW), .CTX_W(CTX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_ctx(reg_ctx),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .status(status), .mask_q(mask_q),
  .rt_q(rt_q), .irq_out(irq_out)
);

// File: tb/tb_irq_steer.sv
module tb_irq_steer;
  localparam int CLK_PERIOD = 10;
  localparam int N_OUT = 15, N_CTX = 2, NO = N_CTX * N_OUT;

  logic          clk = 0, rst_n = 0;
  logic [31:0]   irq_in = '0;
  logic          reg_wr = 0, reg_rd = 0;
  logic [0:0]    reg_ctx = '0;
  logic [4:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NO-1:0] irq_out;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] m_mask [N_CTX];
  logic [31:0] m_rt   [N_CTX][4];

  irq_steer dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [NO-1:0] model_out(logic [31:0] in);
    logic [NO-1:0] r = '0;
    for (int c = 0; c < N_CTX; c++)
      for (int i = 0; i < 32; i++) begin
        logic [3:0] cd = m_rt[c][3 - (i >> 3)][(i & 7) * 4 +: 4];
        if (m_mask[c][i] && in[i] && cd != 0 && int'(cd) <= N_OUT)
          r[c * N_OUT + int'(cd) - 1] = 1'b1;
      end
    return r;
  endfunction

  function automatic logic [31:0] model_rd(int c, logic [4:0] a, logic [31:0] in);
    int w = int'(a >> 2);
    if (w == 0) return m_mask[c];
    if (w == 1) return in;
    if (w >= 2 && w < 6) return m_rt[c][w - 2];
    return '0;
  endfunction

  task automatic wr(int c, logic [4:0] a, logic [31:0] d);
    int w = int'(a >> 2);
    @(negedge clk);
    reg_wr = 1; reg_ctx = 1'(c); reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
    if (w == 0) m_mask[c] = d;
    else if (w >= 2 && w < 6) m_rt[c][w - 2] = d;
  endtask

  task automatic rd(int c, logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1; reg_ctx = 1'(c); reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  bit done = 0;
  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    for (int c = 0; c < N_CTX; c++) begin
      m_mask[c] = '0;
      for (int j = 0; j < 4; j++) m_rt[c][j] = '0;
    end
    repeat (3) @(negedge clk);
    check("R1 out in reset", 32'(irq_out), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 out after reset", 32'(irq_out), 0);
    check("R1 rdata after reset", reg_rdata, 0);
    rd(0, 5'h00, d); check("R1 mask ctx0", d, 0);
    rd(1, 5'h14, d); check("R1 routing ctx1", d, 0);

    // R3/R4: input 31 top nibble of word 0, input 0 low nibble of word 3
    wr(0, 5'h08, 32'h5000_0000);
    wr(0, 5'h14, 32'h0000_0001);
    wr(0, 5'h00, 32'h8000_0001);
    irq_in = 32'h8000_0001; settle();
    check("R3 packing", 32'(irq_out), 32'h0000_0011);
    // R4: code 15 reaches line 14 (input 23, word 1 top nibble)
    wr(0, 5'h0C, 32'hF000_0000);
    wr(0, 5'h00, 32'h0080_0000);
    irq_in = 32'h0080_0000; settle();
    check("R4 code 15", 32'(irq_out), 32'h0000_4000);
    // R4: enabled but code 0
    wr(0, 5'h00, 32'h0000_0020);
    irq_in = 32'h0000_0020; settle();
    check("R4 code 0", 32'(irq_out), 0);
    // R5: input 31 routed but disabled
    wr(0, 5'h00, 32'h0000_0001);
    irq_in = 32'h8000_0001; settle();
    check("R5 mask blocks", 32'(irq_out), 32'h0000_0001);

    // R6: same input, different line per context
    wr(1, 5'h08, 32'h2000_0000);
    wr(1, 5'h00, 32'h8000_0000);
    wr(0, 5'h00, 32'h8000_0000);
    irq_in = 32'h8000_0000; settle();
    check("R6 per-context steering", 32'(irq_out), 32'h0001_0010);
    rd(0, 5'h08, d); check("R6 ctx0 routing kept", d, 32'h5000_0000);
    rd(1, 5'h14, d); check("R6 ctx1 word3 untouched", d, 0);

    // R7: OR of two inputs on one line, then latency
    wr(0, 5'h08, 32'h5500_0000);
    wr(0, 5'h00, 32'hC000_0000);
    irq_in = 32'hC000_0000; settle();
    check("R7 both high", 32'(irq_out), 32'h0001_0010);
    irq_in = 32'h4000_0000; settle();
    check("R7 one of two high", 32'(irq_out), 32'h0000_0010);
    irq_in = 32'h0;
    @(negedge clk); @(negedge clk);
    check("R7 latency hold", 32'(irq_out), 32'h0000_0010);
    @(negedge clk);
    check("R7 latency release", 32'(irq_out), 0);

    // R8: status and unmapped writes ignored
    irq_in = 32'h1234_5678; settle();
    wr(0, 5'h04, 32'hFFFF_FFFF);
    wr(0, 5'h18, 32'hFFFF_FFFF);
    wr(1, 5'h1C, 32'hFFFF_FFFF);
    rd(0, 5'h04, d); check("R2 R8 status", d, 32'h1234_5678);
    rd(0, 5'h00, d); check("R8 mask kept", d, 32'hC000_0000);
    rd(1, 5'h18, d); check("R8 unmapped read", d, 0);
    check("R8 outputs", 32'(irq_out), 32'(model_out(irq_in)));

    // Random mix
    for (int it = 0; it < 200; it++) begin
      int nw = 1 + int'($urandom_range(2, 0));
      for (int k = 0; k < nw; k++) begin
        int c = int'($urandom_range(1, 0));
        int sel = int'($urandom_range(4, 0));
        logic [4:0] a = (sel == 0) ? 5'h00 : 5'(4 + 4 * sel);
        wr(c, a, $urandom);
      end
      irq_in = $urandom & $urandom;
      settle();
      check("R7 random outputs", 32'(irq_out), 32'(model_out(irq_in)));
      begin
        int c = int'($urandom_range(1, 0));
        logic [4:0] a = 5'(4 * $urandom_range(6, 0));
        rd(c, a, d);
        check("R2 random readback", d, model_rd(c, a, irq_in));
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule